// File: doc/BRIEF.md
# Control Response Rate Table Builder

The block fills a small table of response-rate entries that a transmitter uses when it answers a received frame with a control frame. Software provides a 12-bit basic-rate bitmap and a band selection, then pulses `start`. The block copies both into internal registers and visits thirteen table slots in a fixed order, writing one slot per clock cycle through a simple write port. Four slots cover the CCK rates and nine cover the OFDM rates.

For each slot the block picks the response rate by searching the bitmap downward from the slot's own rate. CCK slots fall back to 1 Mb/s. OFDM slots either clamp to 24 Mb/s, when the bitmap has no OFDM basic rate, or search down to 6 Mb/s and fall back to 24 Mb/s. Each OFDM entry carries a signal code and a reserve time, and both depend on the band. The block also reports the highest basic rate in each family and a packet type derived from the latched settings.

Rate indices 0 to 11 stand for 1, 2, 5.5, 11, 6, 9, 12, 18, 24, 36, 48 and 54 Mb/s, and bitmap bit i marks index i as basic. Band codes: 0 = 5 GHz OFDM, 1 = CCK only, 2 or 3 = mixed 2.4 GHz.

Top module: `rsp_rate_tbl_builder`

## Requirements
- R1: During and after reset, `busy`, `done` and `wr_en` are low. The latched settings are bitmap 0 and band 0, so `top_ofdm` = 8, `top_cck` = 0 and `pkt_type` = 0.
- R2: If `start` is seen high on a clock edge while the block is idle, `busy` and `wr_en` go high in the next cycle. Exactly 13 writes then follow on consecutive cycles, with `wr_addr` stepping 0, 1, ..., 12.
- R3: `done` is high for exactly one cycle, in the cycle after the write to address 12. `busy` and `wr_en` are low in that cycle.
- R4: A `start` that arrives while `busy` is high has no effect: it causes no extra writes and no restart. `basic_rates` and `band` are sampled only on an accepted `start`.
- R5: Addresses 0 to 3 are the CCK slots for rate indices 0 to 3. Each word holds, in bits 3:0, the highest index j with 1 <= j <= slot index and bitmap bit j set, or 0 if there is none. Bits 15:4 are zero.
- R6: Addresses 4 to 12 are the OFDM slots. Addresses 4 to 8 use rate indices 4 to 8 directly. Addresses 9, 10 and 11 use the OFDM search result for indices 9, 10 and 11. Address 12 uses the search result for index 11.
- R7: The OFDM search for index r works as follows. If bitmap bits 11:4 are all zero, the result is min(r, 8). Otherwise the result is the highest set index j with 4 <= j <= r, or 8 if there is none.
- R8: In band 0, an OFDM word is {reserve time, signal code}, with the signal code in bits 7:0. For rate indices 4 to 11 the codes are 9B, 9F, 9A, 9E, 99, 9D, 98, 9C (hex) and the reserve times are 44, 36, 32, 28, 28, 24, 24, 24.
- R9: In bands 1, 2 and 3 the signal code has bit 4 cleared and the reserve time is 6 larger than in band 0.
- R10: `top_ofdm` is the highest set index among bitmap bits 11:4, or 8 if none is set. `top_cck` is the highest set index among bits 3:0, or 0 if none is set. Both are taken from the latched bitmap.
- R11: `pkt_type` is 0 in band 0 and 1 in band 1. In bands 2 and 3 it is 2 if any of bits 11:4 of the latched bitmap is set, and 1 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a table fill (ignored while busy) |
| basic_rates | input | 12 | Basic-rate bitmap, bit i marks rate index i |
| band | input | 2 | Band: 0 = 5 GHz, 1 = CCK only, 2 or 3 = mixed |
| busy | output | 1 | High while table writes are issued |
| done | output | 1 | One-cycle pulse after the last write |
| wr_en | output | 1 | Table write strobe |
| wr_addr | output | 4 | Table slot address |
| wr_data | output | 16 | Table entry word |
| top_ofdm | output | 4 | Highest OFDM basic rate index |
| top_cck | output | 4 | Highest CCK basic rate index |
| pkt_type | output | 2 | 0 = 5 GHz OFDM, 1 = CCK, 2 = mixed with OFDM |

## Verification
Two events can fall on the same clock edge: the final table write and a fresh `start` request. The bench provokes this twice. First it raises `start`, with a different bitmap, in the cycle of the write to address 12; it then expects a single `done` and no further writes. Then it raises `start` in the `done` cycle itself and expects a complete second fill that uses the new settings. A scoreboard holds the expected words for every fill, so any stray, missing or stale write shows up as a mismatch or as an unexpected entry.

// File: rtl/rrt_pkg.sv
// Package: shared constants, types and rate functions for the response
// rate table builder. Assumes rate indices 0..3 are CCK and 4..11 are OFDM.
package rrt_pkg;
    localparam int NUM_RATES = 12;
    localparam int RATE_W    = 4;
    localparam int NUM_CCK   = 4;
    localparam int NUM_SLOTS = 13;
    localparam int WORD_W    = 16;

    localparam logic [RATE_W-1:0] IDX_1M  = 4'd0;
    localparam logic [RATE_W-1:0] IDX_6M  = 4'd4;
    localparam logic [RATE_W-1:0] IDX_24M = 4'd8;
    localparam logic [RATE_W-1:0] IDX_54M = 4'd11;

    typedef enum logic [1:0] {
        BAND_5G   = 2'd0,
        BAND_CCK  = 2'd1,
        BAND_MIX  = 2'd2,
        BAND_MIX3 = 2'd3
    } band_t;

    typedef enum logic [1:0] {
        PKT_OFDM5   = 2'd0,
        PKT_CCK     = 2'd1,
        PKT_MIXOFDM = 2'd2
    } pkt_t;

    // Downward search over the CCK bits: highest set index in 1..r, else 1 Mb/s.
    function automatic logic [RATE_W-1:0] cck_search(input logic [RATE_W-1:0] r,
                                                     input logic [NUM_RATES-1:0] bm);
        logic [RATE_W-1:0] res;
        res = IDX_1M;
        for (int i = 1; i < NUM_CCK; i++)
            if (RATE_W'(i) <= r && bm[i]) res = RATE_W'(i);
        return res;
    endfunction

    // OFDM search: clamp to 24 Mb/s when no OFDM bit is set, else search down to 6 Mb/s.
    function automatic logic [RATE_W-1:0] ofdm_search(input logic [RATE_W-1:0] r,
                                                      input logic [NUM_RATES-1:0] bm);
        logic [RATE_W-1:0] res;
        if (bm[NUM_RATES-1:NUM_CCK] == '0) begin
            res = (r > IDX_24M) ? IDX_24M : r;
        end else begin
            res = IDX_24M;
            for (int i = NUM_CCK; i < NUM_RATES; i++)
                if (RATE_W'(i) <= r && bm[i]) res = RATE_W'(i);
        end
        return res;
    endfunction

    // Signal code in 5 GHz form for an OFDM rate index.
    function automatic logic [7:0] sig_code(input logic [RATE_W-1:0] r);
        case (r)
            4'd4:    return 8'h9B;
            4'd5:    return 8'h9F;
            4'd6:    return 8'h9A;
            4'd7:    return 8'h9E;
            4'd9:    return 8'h9D;
            4'd10:   return 8'h98;
            4'd11:   return 8'h9C;
            default: return 8'h99;
        endcase
    endfunction

    // Reserve time in 5 GHz form for an OFDM rate index.
    function automatic logic [7:0] rsv_time(input logic [RATE_W-1:0] r);
        case (r)
            4'd4:              return 8'd44;
            4'd5:              return 8'd36;
            4'd6:              return 8'd32;
            4'd9, 4'd10, 4'd11: return 8'd24;
            default:           return 8'd28;
        endcase
    endfunction
endpackage

// File: rtl/rrt_seq.sv
// Sequencer: accepts start when idle, latches the settings and steps a slot
// counter through every table slot, one per cycle, then pulses done.
// Assumes start is synchronous to clk.
module rrt_seq
    import rrt_pkg::*;
#(
    parameter int SLOTS = NUM_SLOTS,
    localparam int SLOT_W = $clog2(SLOTS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [NUM_RATES-1:0] bm_in,
    input  band_t                band_in,
    output logic                 busy,
    output logic                 done,
    output logic [SLOT_W-1:0]    slot,
    output logic [NUM_RATES-1:0] cfg_bm,
    output band_t                cfg_band
);
    localparam logic [SLOT_W-1:0] LAST = SLOT_W'(SLOTS - 1);

    // Run control, slot counter and settings capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            done     <= 1'b0;
            slot     <= '0;
            cfg_bm   <= '0;
            cfg_band <= BAND_5G;
        end else begin
            done <= 1'b0;
            if (!busy && start) begin
                busy     <= 1'b1;
                slot     <= '0;
                cfg_bm   <= bm_in;
                cfg_band <= band_in;
            end else if (busy) begin
                if (slot == LAST) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    slot <= slot + 1'b1;
                end
            end
        end
    end

    p_done_after_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(busy) && !busy);
    p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_cfg_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) |-> $stable(cfg_bm) && $stable(cfg_band));
endmodule

// File: rtl/rrt_slot_words.sv
// Slot word generator: computes the table word of every slot in parallel from
// the latched settings. Slots 0..3 are CCK, slots 4..12 are OFDM (12 mirrors 11).
module rrt_slot_words
    import rrt_pkg::*;
#(
    parameter int SLOTS = NUM_SLOTS
) (
    input  logic [NUM_RATES-1:0]           cfg_bm,
    input  band_t                          cfg_band,
    output logic [SLOTS-1:0][WORD_W-1:0]   words
);
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        logic [RATE_W-1:0] rate;
        if (s < NUM_CCK) begin : g_cck
            // CCK slot: downward search result, rate index in the low nibble.
            always_comb begin
                rate     = cck_search(RATE_W'(s), cfg_bm);
                words[s] = {{(WORD_W-RATE_W){1'b0}}, rate};
            end
        end else begin : g_ofdm
            logic [7:0] sig;
            logic [7:0] rsv;
            // OFDM slot: choose the rate, then encode signal code and reserve time.
            always_comb begin
                if (s <= int'(IDX_24M))
                    rate = RATE_W'(s);
                else if (s < NUM_RATES)
                    rate = ofdm_search(RATE_W'(s), cfg_bm);
                else
                    rate = ofdm_search(IDX_54M, cfg_bm);
                sig = sig_code(rate);
                rsv = rsv_time(rate);
                if (cfg_band != BAND_5G) begin
                    sig = sig & 8'hEF;
                    rsv = rsv + 8'd6;
                end
                words[s] = {rsv, sig};
            end
        end
    end
endmodule

// File: rtl/rrt_top_rates.sv
// Summary outputs: highest basic rate per family and the packet type, from
// the latched settings. Assumes bits 11:4 are OFDM and 3:0 are CCK.
module rrt_top_rates
    import rrt_pkg::*;
(
    input  logic [NUM_RATES-1:0] cfg_bm,
    input  band_t                cfg_band,
    output logic [RATE_W-1:0]    top_ofdm,
    output logic [RATE_W-1:0]    top_cck,
    output pkt_t                 pkt_type
);
    // Priority scans for the top rates and the packet type decode.
    always_comb begin
        top_ofdm = IDX_24M;
        top_cck  = IDX_1M;
        for (int i = NUM_CCK; i < NUM_RATES; i++)
            if (cfg_bm[i]) top_ofdm = RATE_W'(i);
        for (int i = 0; i < NUM_CCK; i++)
            if (cfg_bm[i]) top_cck = RATE_W'(i);
        case (cfg_band)
            BAND_5G:  pkt_type = PKT_OFDM5;
            BAND_CCK: pkt_type = PKT_CCK;
            default:  pkt_type = (cfg_bm[NUM_RATES-1:NUM_CCK] != '0) ? PKT_MIXOFDM : PKT_CCK;
        endcase
    end
endmodule

// File: rtl/rsp_rate_tbl_builder.sv
// Top: control response rate table builder. Writes one table slot per cycle
// after an accepted start; the write port is driven straight from the
// sequencer state and the parallel slot words.
module rsp_rate_tbl_builder
    import rrt_pkg::*;
#(
    localparam int ADDR_W = $clog2(NUM_SLOTS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [NUM_RATES-1:0] basic_rates,
    input  logic [1:0]           band,
    output logic                 busy,
    output logic                 done,
    output logic                 wr_en,
    output logic [ADDR_W-1:0]    wr_addr,
    output logic [WORD_W-1:0]    wr_data,
    output logic [RATE_W-1:0]    top_ofdm,
    output logic [RATE_W-1:0]    top_cck,
    output logic [1:0]           pkt_type
);
    logic [ADDR_W-1:0]                 slot;
    logic [NUM_RATES-1:0]              cfg_bm;
    band_t                             cfg_band;
    logic [NUM_SLOTS-1:0][WORD_W-1:0]  words;
    pkt_t                              pkt;

    rrt_seq #(.SLOTS(NUM_SLOTS)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .bm_in    (basic_rates),
        .band_in  (band_t'(band)),
        .busy     (busy),
        .done     (done),
        .slot     (slot),
        .cfg_bm   (cfg_bm),
        .cfg_band (cfg_band)
    );

    rrt_slot_words #(.SLOTS(NUM_SLOTS)) u_words (
        .cfg_bm   (cfg_bm),
        .cfg_band (cfg_band),
        .words    (words)
    );

    rrt_top_rates u_top (
        .cfg_bm   (cfg_bm),
        .cfg_band (cfg_band),
        .top_ofdm (top_ofdm),
        .top_cck  (top_cck),
        .pkt_type (pkt)
    );

    // Write port and packet type from internal state.
    always_comb begin
        wr_en    = busy;
        wr_addr  = slot;
        wr_data  = words[slot];
        pkt_type = pkt;
    end

    p_addr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && $past(wr_en) |-> wr_addr == $past(wr_addr) + 1'b1);
    p_first_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !$past(wr_en) |-> wr_addr == '0);
    p_cck_basic_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_addr < ADDR_W'(NUM_CCK) && wr_data[RATE_W-1:0] != '0
        |-> cfg_bm[wr_data[RATE_W-1:0]]);
    p_top_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
        top_ofdm >= IDX_6M && top_ofdm <= IDX_54M && top_cck < RATE_W'(NUM_CCK));
endmodule

// File: tb/rsp_rate_tbl_builder_test.sv
module rsp_rate_tbl_builder_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [11:0] basic_rates = '0;
    logic [1:0]  band = '0;
    logic        busy, done, wr_en;
    logic [3:0]  wr_addr;
    logic [15:0] wr_data;
    logic [3:0]  top_ofdm, top_cck;
    logic [1:0]  pkt_type;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    typedef struct {
        int          addr;
        logic [15:0] data;
        string       tag;
    } item_t;
    item_t sbq[$];

    always #2.5 clk = ~clk;

    rsp_rate_tbl_builder uut (
        .clk(clk), .rst_n(rst_n), .start(start), .basic_rates(basic_rates),
        .band(band), .busy(busy), .done(done), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .top_ofdm(top_ofdm), .top_cck(top_cck), .pkt_type(pkt_type)
    );

    localparam logic [7:0] SIG5 [8] = '{8'h9B, 8'h9F, 8'h9A, 8'h9E, 8'h99, 8'h9D, 8'h98, 8'h9C};
    localparam int         RSV5 [8] = '{44, 36, 32, 28, 28, 24, 24, 24};

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int m_cck(int r, logic [11:0] bm);
        for (int i = r; i > 0; i--) if (bm[i]) return i;
        return 0;
    endfunction

    function automatic int m_ofdm(int r, logic [11:0] bm);
        if (bm[11:4] == 0) return (r > 8) ? 8 : r;
        for (int i = r; i > 3; i--) if (bm[i]) return i;
        return 8;
    endfunction

    function automatic logic [15:0] m_word(int s, logic [11:0] bm, logic [1:0] bd);
        int rate;
        logic [7:0] sig;
        int rsv;
        if (s < 4) return 16'(m_cck(s, bm));
        if (s <= 8) rate = s;
        else if (s == 12) rate = m_ofdm(11, bm);
        else rate = m_ofdm(s, bm);
        sig = SIG5[rate-4];
        rsv = RSV5[rate-4];
        if (bd != 2'd0) begin
            sig[4] = 1'b0;
            rsv = rsv + 6;
        end
        return {8'(rsv), sig};
    endfunction

    // Driver: raise start now (caller is at a falling edge) and queue expectations.
    task automatic kick_now(input logic [11:0] bm, input logic [1:0] bd);
        start = 1'b1;
        basic_rates = bm;
        band = bd;
        for (int s = 0; s < 13; s++) begin
            item_t it;
            it.addr = s;
            it.data = m_word(s, bm, bd);
            it.tag  = (s < 4) ? "R5 R2" : ((bd == 2'd0) ? "R6 R7 R8 R2" : "R6 R7 R9 R2");
            sbq.push_back(it);
        end
        @(negedge clk);
        start = 1'b0;
        basic_rates = ~bm;
        band = ~bd;
    endtask

    task automatic kick(input logic [11:0] bm, input logic [1:0] bd);
        @(negedge clk);
        kick_now(bm, bd);
    endtask

    task automatic wait_done();
        do @(negedge clk); while (!done);
    endtask

    task automatic check_summary(input logic [11:0] bm, input logic [1:0] bd);
        int eo, ec, ep;
        eo = 8;
        for (int i = 4; i < 12; i++) if (bm[i]) eo = i;
        ec = 0;
        for (int i = 0; i < 4; i++) if (bm[i]) ec = i;
        if (bd == 2'd0) ep = 0;
        else if (bd == 2'd1) ep = 1;
        else ep = (bm[11:4] != 0) ? 2 : 1;
        check(top_ofdm == 4'(eo), "R10 top_ofdm", top_ofdm, eo);
        check(top_cck == 4'(ec), "R10 top_cck", top_cck, ec);
        check(pkt_type == 2'(ep), "R11 pkt_type", pkt_type, ep);
    endtask

    // Monitor: pop and compare every write, judge done timing and write count.
    int  run_writes = 0;
    bit  last_was_12 = 0;
    bit  done_prev = 0;
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (wr_en) begin
                    if (sbq.size() == 0) begin
                        check(0, "R4 unexpected write", wr_addr, 0);
                    end else begin
                        item_t it;
                        it = sbq.pop_front();
                        check(busy && int'(wr_addr) == it.addr && wr_data == it.data,
                              $sformatf("%s slot %0d", it.tag, it.addr), wr_data, it.data);
                    end
                    run_writes++;
                end
                if (done) begin
                    check(last_was_12 && !busy && !wr_en && !done_prev, "R3 done timing",
                          {busy, wr_en, done_prev}, 0);
                    check(run_writes == 13, "R2 writes per run", run_writes, 13);
                    run_writes = 0;
                end
                last_was_12 = wr_en && wr_addr == 4'd12;
                done_prev   = done;
            end
        end
    end

    initial begin
        #1000000;
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: state while reset is held and just after release
        check(!busy && !done && !wr_en, "R1 controls in reset", {busy, done, wr_en}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && !wr_en, "R1 controls after reset", {busy, done, wr_en}, 0);
        check(top_ofdm == 4'd8 && top_cck == 4'd0, "R1 top rates", {top_ofdm, top_cck}, 8'h80);
        check(pkt_type == 2'd0, "R1 pkt_type", pkt_type, 0);

        // No basic rates, 5 GHz: CCK fallback, OFDM clamp (R7)
        kick(12'h000, 2'd0); wait_done(); check_summary(12'h000, 2'd0);
        // All basic rates, CCK band (R9)
        kick(12'hFFF, 2'd1); wait_done(); check_summary(12'hFFF, 2'd1);
        // Sparse OFDM set, mixed band: searches that fall back and hit (R7 R11)
        kick(12'b0000_0101_0010, 2'd2); wait_done(); check_summary(12'b0000_0101_0010, 2'd2);
        // CCK only rates, mixed band code 3: clamp path, pkt CCK (R11)
        kick(12'b0000_0000_1101, 2'd3); wait_done(); check_summary(12'b0000_0000_1101, 2'd3);
        // Only 54 Mb/s OFDM, 5 GHz
        kick(12'h800, 2'd0); wait_done(); check_summary(12'h800, 2'd0);
        // 48 Mb/s and 2 Mb/s, mixed
        kick(12'h402, 2'd2); wait_done(); check_summary(12'h402, 2'd2);

        // R4: starts during a run (mid-run and on the last write) are ignored
        kick(12'h0A5, 2'd0);
        repeat (4) @(negedge clk);
        start = 1'b1; basic_rates = 12'hFFF; band = 2'd1;
        @(negedge clk);
        start = 1'b0;
        while (!(wr_en && wr_addr == 4'd12)) @(negedge clk);
        start = 1'b1; basic_rates = 12'h800; band = 2'd2;
        @(negedge clk);
        start = 1'b0;
        check(done == 1'b1, "R3 done after last write", done, 1);
        repeat (6) @(negedge clk);
        check(!busy && sbq.size() == 0, "R4 start while busy ignored", busy, 0);
        check_summary(12'h0A5, 2'd0);

        // Back-to-back: start in the done cycle is accepted (R2)
        kick(12'h130, 2'd2);
        wait_done();
        kick_now(12'h00F, 2'd0);
        check(busy && wr_en && wr_addr == 4'd0, "R2 restart from done cycle", wr_addr, 0);
        wait_done();
        check_summary(12'h00F, 2'd0);

        repeat (4) @(negedge clk);
        check(sbq.size() == 0, "R2 all expected writes seen", sbq.size(), 0);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule